// File: doc/BRIEF.md
# Timed Solenoid Valve Sequencer

This block drives a bank of solenoid valves on command from a host register port. Each valve is energized in two separate switch steps. The supply-connect switch closes first. On the next millisecond tick the drive switch closes and stays closed for a host-programmed open time. When that time runs out, the drive switch opens first and the supply switch opens one tick later. A valve starts when the host pulses its fire strobe and the valve's bit in the enable register is set. An emergency request line per valve starts the same sequence whether or not the valve is enabled, so no host action is needed.

Each valve has two feedback inputs. The voltage-sense comparator input passes through a two-flop synchronizer. The position-switch input passes through the same synchronizer and then a tick-based debouncer. Together these give a live status word. A sticky event word records every change of either kind of feedback. Reading the event word returns its contents and clears it. All host reads are registered and return one cycle after the read strobe.

Top module: `vlv_ctrl`

## Requirements
- R1: After reset, every supply and drive output is low, the enable register is 0, the open time is 50, and both status words read 0.
- R2: A write with wr_sel=0 loads the enable register from wr_data[NV-1:0]; wr_sel=1 loads the open time. A read strobe with rd_sel 0 (live status), 1 (event), 2 (enable) or 3 (open time) returns that value on rd_data in the following cycle.
- R3: The open time is held in 1 ms ticks. A written value below 50 is stored as 50, and a value above 30000 is stored as 30000.
- R4: supply_on rises at least one cycle before drive_on. drive_on then stays high for exactly (open time) tick periods.
- R5: At the end of the sequence drive_on falls first. supply_on falls exactly one tick period later.
- R6: A fire strobe for a valve whose enable bit is 0 has no effect.
- R7: A fire strobe for a valve that is already in its sequence is ignored. The running sequence keeps its length, and no second sequence follows.
- R8: An emergency request starts the sequence even when the valve's enable bit is 0.
- R9: Live-status bits [NV-1:0] show the synchronized voltage-sense inputs.
- R10: Live-status bits [2NV-1:NV] show the debounced position inputs. A new position value is accepted only after it has differed from the accepted value for 8 consecutive ticks, so a shorter glitch changes nothing.
- R11: An event bit sets on any change of its live-status bit and stays set until the event word is read, which clears it. If a change and a clearing read fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 1 ms timebase strobe |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Write target: 0 enable, 1 open time |
| wr_data | input | OTW | Write data |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 2 | Read source: 0 live, 1 event, 2 enable, 3 open time |
| rd_data | output | OTW | Registered read data |
| fire | input | NV | Per-valve host start strobe |
| emerg | input | NV | Per-valve emergency start request |
| volt_sense | input | NV | Comparator voltage-sense feedback |
| pos_sw | input | NV | Raw position-switch feedback |
| supply_on | output | NV | Supply-connect switch drive |
| drive_on | output | NV | Drive switch control |

## Verification
The host's clearing read of the event word and a new feedback change can land on the same clock edge. The bench provokes this by changing a voltage-sense input and timing the event read so that it is sampled on the third edge afterward. That is the edge where the synchronized change reaches the status register. The read must return the old, cleared word, and a second read must then show the new event bit, because setting has priority over clearing.

// File: rtl/vlv_pkg.sv
package vlv_pkg;
  typedef enum logic [1:0] {
    V_IDLE = 2'd0,
    V_CONN = 2'd1,
    V_DRV  = 2'd2,
    V_REL  = 2'd3
  } vstate_t;

  localparam logic [1:0] RS_CUR = 2'd0;
  localparam logic [1:0] RS_EVT = 2'd1;
  localparam logic [1:0] RS_EN  = 2'd2;
  localparam logic [1:0] RS_OT  = 2'd3;

  localparam logic WS_EN = 1'b0;
  localparam logic WS_OT = 1'b1;
endpackage

// File: rtl/vlv_seq.sv
module vlv_seq
  import vlv_pkg::*;
#(
  parameter int OTW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           start,
  input  logic [OTW-1:0] ot_ticks,
  output logic           supply_o,
  output logic           drive_o
);
  vstate_t        st_q, st_d;
  logic [OTW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      V_IDLE: if (start) begin
        st_d  = V_CONN;
        cnt_d = ot_ticks;
      end
      V_CONN: if (tick) st_d = V_DRV;
      V_DRV: if (tick) begin
        if (cnt_q <= OTW'(1)) st_d = V_REL;
        else cnt_d = cnt_q - 1'b1;
      end
      V_REL: if (tick) st_d = V_IDLE;
      default: st_d = V_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= V_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign supply_o = (st_q != V_IDLE);
  assign drive_o  = (st_q == V_DRV);

  // R4
  drive_after_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_o) |-> $past(supply_o));

  // R5
  supply_after_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_o) |-> !$past(drive_o));

  // R4
  timer_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == V_DRV) |-> (cnt_q != '0));
endmodule

// File: rtl/vlv_debounce.sv
module vlv_debounce #(
  parameter int DB_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic deb
);
  localparam int CW = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;

  logic [1:0]    sync_q;
  logic          deb_q, deb_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    deb_d = deb_q;
    cnt_d = cnt_q;
    if (sync_q[1] == deb_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == CW'(DB_TICKS - 1)) begin
        deb_d = sync_q[1];
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      deb_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw};
      deb_q  <= deb_d;
      cnt_q  <= cnt_d;
    end
  end

  assign deb = deb_q;

  // R10
  deb_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(deb_q) |-> $past(tick));
endmodule

// File: rtl/vlv_status.sv
module vlv_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live,
  input  logic         clr,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] cur_q, evt_q, evt_d;

  always_comb begin
    evt_d = (clr ? '0 : evt_q) | (live ^ cur_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      evt_q <= '0;
    end else begin
      cur_q <= live;
      evt_q <= evt_d;
    end
  end

  assign cur_o = cur_q;
  assign evt_o = evt_q;

  // R11
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R11
  evt_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_q ^ $past(cur_q)) & ~evt_q) == '0);
endmodule

// File: rtl/vlv_ctrl.sv
module vlv_ctrl
  import vlv_pkg::*;
#(
  parameter int NV       = 4,
  parameter int OTW      = 16,
  parameter int OT_MIN   = 50,
  parameter int OT_MAX   = 30000,
  parameter int DB_TICKS = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [OTW-1:0] wr_data,
  input  logic           rd_en,
  input  logic [1:0]     rd_sel,
  output logic [OTW-1:0] rd_data,
  input  logic [NV-1:0]  fire,
  input  logic [NV-1:0]  emerg,
  input  logic [NV-1:0]  volt_sense,
  input  logic [NV-1:0]  pos_sw,
  output logic [NV-1:0]  supply_on,
  output logic [NV-1:0]  drive_on
);
  localparam int SW = 2 * NV;
  localparam logic [OTW-1:0] OT_LO = OTW'(OT_MIN);
  localparam logic [OTW-1:0] OT_HI = OTW'(OT_MAX);

  logic [NV-1:0]  en_q, en_d;
  logic [OTW-1:0] ot_q, ot_d, ot_clamp;
  logic [OTW-1:0] rd_q, rd_d;
  logic [NV-1:0]  volt_m, volt_s;
  logic [NV-1:0]  pos_deb;
  logic [NV-1:0]  start;
  logic [SW-1:0]  cur, evt;
  logic           evt_clr;

  always_comb begin
    if (wr_data < OT_LO)      ot_clamp = OT_LO;
    else if (wr_data > OT_HI) ot_clamp = OT_HI;
    else                      ot_clamp = wr_data;
  end

  always_comb begin
    en_d = en_q;
    ot_d = ot_q;
    if (wr_en && wr_sel == WS_EN) en_d = wr_data[NV-1:0];
    if (wr_en && wr_sel == WS_OT) ot_d = ot_clamp;
  end

  assign evt_clr = rd_en && (rd_sel == RS_EVT);

  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      unique case (rd_sel)
        RS_CUR:  rd_d = OTW'(cur);
        RS_EVT:  rd_d = OTW'(evt);
        RS_EN:   rd_d = OTW'(en_q);
        default: rd_d = ot_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      ot_q   <= OT_LO;
      rd_q   <= '0;
      volt_m <= '0;
      volt_s <= '0;
    end else begin
      en_q   <= en_d;
      ot_q   <= ot_d;
      rd_q   <= rd_d;
      volt_m <= volt_sense;
      volt_s <= volt_m;
    end
  end

  assign rd_data = rd_q;
  assign start   = (fire & en_q) | emerg;

  for (genvar i = 0; i < NV; i++) begin : g_valve
    vlv_seq #(.OTW(OTW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .start    (start[i]),
      .ot_ticks (ot_q),
      .supply_o (supply_on[i]),
      .drive_o  (drive_on[i])
    );

    vlv_debounce #(.DB_TICKS(DB_TICKS)) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .raw   (pos_sw[i]),
      .deb   (pos_deb[i])
    );

    // R6 R8
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(supply_on[i]) |-> $past(emerg[i] || (fire[i] && en_q[i])));
  end

  vlv_status #(.W(SW)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .live  ({pos_deb, volt_s}),
    .clr   (evt_clr),
    .cur_o (cur),
    .evt_o (evt)
  );

  // R3
  ot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_q >= OT_LO) && (ot_q <= OT_HI));
endmodule

// File: tb/tb_vlv_ctrl.sv
`timescale 1ns/1ps
module tb_vlv_ctrl;
  localparam int NV = 4;
  localparam int OTW = 16;
  localparam int TP = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick = 1'b0;
  logic           wr_en = 1'b0;
  logic           wr_sel = 1'b0;
  logic [OTW-1:0] wr_data = '0;
  logic           rd_en = 1'b0;
  logic [1:0]     rd_sel = 2'd0;
  logic [OTW-1:0] rd_data;
  logic [NV-1:0]  fire = '0;
  logic [NV-1:0]  emerg = '0;
  logic [NV-1:0]  volt_sense = '0;
  logic [NV-1:0]  pos_sw = '0;
  logic [NV-1:0]  supply_on, drive_on;

  int n_tests = 0;
  int n_fail = 0;
  logic [OTW-1:0] rv;

  vlv_ctrl #(.NV(NV), .OTW(OTW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .fire(fire), .emerg(emerg), .volt_sense(volt_sense), .pos_sw(pos_sw),
    .supply_on(supply_on), .drive_on(drive_on)
  );

  always #10 clk = ~clk;

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      tick = (tc % TP == 0);
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [OTW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    rv = rd_data;
  endtask

  task automatic measure(int i, bit refire, output int drv, output int tail, output bit order_ok);
    int guard = 0;
    drv = 0; tail = 0; order_ok = 1'b1;
    if (drive_on[i]) order_ok = 1'b0;
    while (!drive_on[i] && guard < 100) begin @(negedge clk); guard++; end
    while (drive_on[i]) begin
      @(negedge clk);
      drv++;
      fire[i] = refire && (drv == 20);
      if (!supply_on[i]) order_ok = 1'b0;
    end
    fire[i] = 1'b0;
    while (supply_on[i] && tail < 100) begin @(negedge clk); tail++; end
  endtask

  task automatic t_reset();
    check(supply_on == '0 && drive_on == '0, "R1 outputs", int'(supply_on), 0);
    rd(2'd0); check(rv == 0, "R1 live status", rv, 0);
    rd(2'd1); check(rv == 0, "R1 event", rv, 0);
    rd(2'd2); check(rv == 0, "R1 enable", rv, 0);
    rd(2'd3); check(rv == 50, "R1 open time", rv, 50);
  endtask

  task automatic t_regs();
    wr(1'b0, 16'h0005); rd(2'd2); check(rv == 5, "R2 enable readback", rv, 5);
    wr(1'b1, 16'd1234); rd(2'd3); check(rv == 1234, "R2 open time readback", rv, 1234);
    wr(1'b1, 16'd10);   rd(2'd3); check(rv == 50, "R3 low clamp", rv, 50);
    wr(1'b1, 16'd40000); rd(2'd3); check(rv == 30000, "R3 high clamp", rv, 30000);
  endtask

  task automatic t_sequence();
    int d, t; bit ok;
    wr(1'b1, 16'd10);
    @(negedge clk); fire[0] = 1'b1;
    @(negedge clk); fire[0] = 1'b0;
    check(supply_on[0] && !drive_on[0], "R4 supply first", int'(drive_on[0]), 0);
    measure(0, 1'b0, d, t, ok);
    check(d == 50 * TP, "R4 drive length at clamp", d, 50 * TP);
    check(ok, "R4 ordering", int'(ok), 1);
    check(t == TP, "R5 release gap", t, TP);
  endtask

  task automatic t_busy();
    int d, t; bit ok;
    wr(1'b1, 16'd60);
    @(negedge clk); fire[2] = 1'b1;
    @(negedge clk); fire[2] = 1'b0;
    measure(2, 1'b1, d, t, ok);
    check(d == 60 * TP, "R7 length kept", d, 60 * TP);
    check(t == TP, "R5 release gap", t, TP);
    repeat (30) begin
      @(negedge clk);
      if (supply_on[2]) begin check(1'b0, "R7 no restart", 1, 0); break; end
    end
    check(supply_on[2] == 1'b0, "R7 idle after", int'(supply_on[2]), 0);
  endtask

  task automatic t_gate();
    bit seen = 1'b0;
    @(negedge clk); fire[1] = 1'b1; fire[3] = 1'b1;
    @(negedge clk); fire = '0;
    repeat (30) begin @(negedge clk); if (supply_on[1] || supply_on[3]) seen = 1'b1; end
    check(!seen, "R6 disabled fire ignored", int'(seen), 0);
  endtask

  task automatic t_emerg();
    int d, t; bit ok;
    @(negedge clk); emerg[1] = 1'b1;
    @(negedge clk); emerg[1] = 1'b0;
    check(supply_on[1] == 1'b1, "R8 emergency start", int'(supply_on[1]), 1);
    measure(1, 1'b0, d, t, ok);
    check(d == 60 * TP, "R8 emergency length", d, 60 * TP);
  endtask

  task automatic t_elec();
    @(negedge clk); volt_sense = 4'b0010;
    repeat (5) @(negedge clk);
    rd(2'd0); check(rv == 16'h0002, "R9 live voltage bit", rv, 2);
    rd(2'd1); check(rv == 16'h0002, "R11 event set", rv, 2);
    rd(2'd1); check(rv == 16'h0000, "R11 cleared by read", rv, 0);
  endtask

  task automatic t_debounce();
    @(negedge clk); pos_sw[2] = 1'b1;
    repeat (5 * TP) @(negedge clk);
    pos_sw[2] = 1'b0;
    repeat (12 * TP) @(negedge clk);
    rd(2'd0); check(rv == 16'h0002, "R10 glitch ignored", rv, 2);
    rd(2'd1); check(rv == 16'h0000, "R10 glitch no event", rv, 0);
    pos_sw[2] = 1'b1;
    repeat (12 * TP) @(negedge clk);
    rd(2'd0); check(rv == 16'h0042, "R10 position accepted", rv, 16'h42);
    rd(2'd1); check(rv == 16'h0040, "R11 mechanical event", rv, 16'h40);
  endtask

  task automatic t_collide();
    rd(2'd1);
    @(negedge clk); volt_sense[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rd_en = 1'b1; rd_sel = 2'd1;
    @(negedge clk); rd_en = 1'b0;
    check(rd_data == 16'h0000, "R11 read before set", rd_data, 0);
    rd(2'd1); check(rv == 16'h0008, "R11 set wins over clear", rv, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_sequence();
    t_busy();
    t_gate();
    t_emerg();
    t_elec();
    t_debounce();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule